// File: doc/BRIEF.md
# DS2 All-Ones Alarm Monitor

This block watches a serial DS2 bit stream for the all-ones alarm condition (AIS). Bits are qualified by a bit-rate enable: only cycles with `bit_en` high carry a line bit. The stream is cut into fixed observation windows of `WIN_LEN` qualified bits, and the zeros in each window are counted. A window holding fewer than `ZERO_LIMIT` zeros is rated *quiet*. A window holding `ZERO_LIMIT` or more zeros is rated *noisy*.

The alarm flag rises only after two quiet windows in a row. It falls only after two noisy windows in a row. A single window of the opposite rating leaves the flag where it is, so the flag has hysteresis. Each change of the flag is marked by a pulse one clock long. The zero count saturates at `ZERO_LIMIT`, so the counter needs only three bits. A one-bit register holds the rating of the previous window.

A two-bit source-mode input tells the block whether the stream comes from an upstream demultiplexer (`00`) or from a direct DS2 input with its own bit clock (`01`). In both cases the monitor treats the stream the same way. Codes `10` and `11` put the monitor in idle: both outputs are low and all state is cleared.

Top module: `ds2_ais_mon`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `ais_flag` and `ais_change` are 0, the window position is 0 and the zero count is 0.
- R2: A window is exactly `WIN_LEN` (default 840) cycles with `bit_en` = 1. Cycles with `bit_en` = 0 neither advance the window nor count their `ser_data` value.
- R3: The zero count of a window saturates at `ZERO_LIMIT` (default 5). A window with any number of zeros at or above that limit is rated noisy.
- R4: A window is quiet when it holds fewer than `ZERO_LIMIT` zeros (0 to 4 by default) and noisy otherwise. The zero on the last bit of a window counts toward that window.
- R5: `ais_flag` goes from 0 to 1 on the clock edge that takes the last bit of the second of two consecutive quiet windows. The flag changes at no other edge except as set out in R9.
- R6: `ais_flag` goes from 1 to 0 on the clock edge that takes the last bit of the second of two consecutive noisy windows.
- R7: A single window whose rating disagrees with the window before it leaves `ais_flag` unchanged.
- R8: `ais_change` is 1 for exactly one cycle after each edge at which `ais_flag` changes state under R5 or R6, and is 0 at all other times.
- R9: With `src_mode` = `10` or `11`, `ais_flag` and `ais_change` are 0 in the same cycle, and window position, zero count, previous rating and flag are cleared. Once a monitoring mode returns, a new window starts and the previous window counts as noisy.
- R10: Modes `00` and `01` process the stream identically.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Qualifies `ser_data` as one line bit |
| ser_data | input | 1 | Serial DS2 data bit |
| src_mode | input | 2 | 00 upstream mux, 01 direct input, 10/11 idle |
| ais_flag | output | 1 | Alarm (all-ones) status |
| ais_change | output | 1 | One-cycle pulse when `ais_flag` toggles |

## Verification
On every cycle, the assertions check several rules: the window position stays in range and holds when no bit is qualified; the zero count never passes its ceiling; the flag moves only on the edge right after a window's last bit; the change pulse coincides with a real toggle and lasts one cycle; and idle mode and reset leave the counters cleared. Several behaviours only show up in the bench's scenarios, which drive whole windows against a reference computed from the rules: the hysteresis itself (two agreeing windows needed, a lone disagreeing window ignored), the exact quiet/noisy boundary at four and five zeros including a zero on the final bit, the restart after an idle stretch, and the equivalence of the two monitoring modes.

// File: rtl/ds2_ais_pkg.sv
// Package: shared types for the DS2 all-ones alarm monitor.
// Assumes: mode encoding fixed by the surrounding demultiplexer control.
package ds2_ais_pkg;

    // Source select codes; bit 1 set means the monitor is idle.
    typedef enum logic [1:0] {
        SRC_UPSTREAM = 2'b00,
        SRC_DIRECT   = 2'b01,
        SRC_IDLE_A   = 2'b10,
        SRC_IDLE_B   = 2'b11
    } src_mode_e;

    // Rating of one observation window.
    typedef enum logic {
        WIN_NOISY = 1'b0,
        WIN_QUIET = 1'b1
    } win_rating_e;

    // True when the select code asks for monitoring.
    function automatic logic mode_is_active(input logic [1:0] mode);
        return (mode == SRC_UPSTREAM) || (mode == SRC_DIRECT);
    endfunction

endpackage

// File: rtl/ds2_ais_win_timer.sv
// Module: window position counter.
// Counts qualified bits from 0 to WIN_LEN-1 and flags the last bit of each
// window. Assumes WIN_LEN >= 2. A synchronous clear restarts the window.
module ds2_ais_win_timer #(
    parameter int WIN_LEN = 840,
    localparam int POS_W  = $clog2(WIN_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bit_en,
    output logic [POS_W-1:0] pos,
    output logic             win_end
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WIN_LEN - 1);

    // Last qualified bit of the current window.
    always_comb begin
        win_end = bit_en && (pos == LAST_POS);
    end

    // Advance the position on each qualified bit, wrap after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pos <= '0;
        end else if (bit_en) begin
            pos <= win_end ? '0 : pos + 1'b1;
        end
    end

endmodule

// File: rtl/ds2_ais_zero_cnt.sv
// Module: saturating zero counter for one window.
// Counts zero bits up to ZERO_LIMIT and rates the window as it closes.
// Assumes win_end is only high together with bit_en.
module ds2_ais_zero_cnt
    import ds2_ais_pkg::*;
#(
    parameter int ZERO_LIMIT = 5,
    localparam int CNT_W     = $clog2(ZERO_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic             win_end,
    output logic [CNT_W-1:0] cnt,
    output win_rating_e      rating
);

    localparam logic [CNT_W-1:0] CEIL = CNT_W'(ZERO_LIMIT);

    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] cnt_next;

    // Count including the current bit, held at the ceiling.
    always_comb begin
        sum      = {1'b0, cnt} + (CNT_W + 1)'(bit_en && !bit_in);
        cnt_next = (sum > {1'b0, CEIL}) ? CEIL : sum[CNT_W-1:0];
    end

    // Window rating from the count that includes the closing bit.
    always_comb begin
        rating = (cnt_next < CEIL) ? WIN_QUIET : WIN_NOISY;
    end

    // Accumulate zeros; restart at each window boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (bit_en) begin
            cnt <= win_end ? '0 : cnt_next;
        end
    end

endmodule

// File: rtl/ds2_ais_hyst.sv
// Module: two-window hysteresis for the alarm flag.
// Keeps the previous window rating; the flag follows a rating only when two
// windows in a row agree. Emits a one-cycle pulse on each flag change.
module ds2_ais_hyst
    import ds2_ais_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        win_end,
    input  win_rating_e rating,
    output logic        flag,
    output logic        change
);

    win_rating_e prev_rating;
    logic        agree_new;

    // Current and previous windows agree on a state the flag is not in.
    always_comb begin
        agree_new = (rating == prev_rating) && (logic'(rating) != flag);
    end

    // Update previous rating, flag and pulse at window boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            prev_rating <= WIN_NOISY;
            flag        <= 1'b0;
            change      <= 1'b0;
        end else begin
            change <= 1'b0;
            if (win_end) begin
                prev_rating <= rating;
                if (agree_new) begin
                    flag   <= logic'(rating);
                    change <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ds2_ais_mon.sv
// Module: DS2 all-ones alarm monitor (top).
// Rates fixed windows of qualified bits by zero count and raises or drops
// the alarm after two agreeing windows. Idle modes clear all state and hold
// the outputs low. Assumes bit_en is synchronous to clk.
module ds2_ais_mon
    import ds2_ais_pkg::*;
#(
    parameter int WIN_LEN    = 840,
    parameter int ZERO_LIMIT = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       ser_data,
    input  logic [1:0] src_mode,
    output logic       ais_flag,
    output logic       ais_change
);

    localparam int POS_W = $clog2(WIN_LEN);
    localparam int CNT_W = $clog2(ZERO_LIMIT + 1);

    logic             active;
    logic             idle_clr;
    logic [POS_W-1:0] win_pos;
    logic             win_end;
    logic [CNT_W-1:0] zero_cnt;
    win_rating_e      win_rating;
    logic             flag_q;
    logic             change_q;

    // Decode the source select into run/idle.
    always_comb begin
        active   = mode_is_active(src_mode);
        idle_clr = !active;
    end

    ds2_ais_win_timer #(.WIN_LEN(WIN_LEN)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (idle_clr),
        .bit_en  (bit_en),
        .pos     (win_pos),
        .win_end (win_end)
    );

    ds2_ais_zero_cnt #(.ZERO_LIMIT(ZERO_LIMIT)) u_zeros (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (idle_clr),
        .bit_en  (bit_en),
        .bit_in  (ser_data),
        .win_end (win_end),
        .cnt     (zero_cnt),
        .rating  (win_rating)
    );

    ds2_ais_hyst u_hyst (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (idle_clr),
        .win_end (win_end),
        .rating  (win_rating),
        .flag    (flag_q),
        .change  (change_q)
    );

    // Hold outputs low at once while idle.
    always_comb begin
        ais_flag   = flag_q && active;
        ais_change = change_q && active;
    end

endmodule

// File: rtl/ds2_ais_mon_chk.sv
// Module: assertion checker for ds2_ais_mon, attached by bind.
// Observes ports and the timer/counter state; drives nothing.
module ds2_ais_mon_chk #(
    parameter int WIN_LEN    = 840,
    parameter int ZERO_LIMIT = 5,
    localparam int POS_W     = $clog2(WIN_LEN),
    localparam int CNT_W     = $clog2(ZERO_LIMIT + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic [1:0]       src_mode,
    input logic             ais_flag,
    input logic             ais_change,
    input logic [POS_W-1:0] pos,
    input logic [CNT_W-1:0] zcnt,
    input logic             win_end
);

    logic run;
    assign run = !src_mode[1];

    // R1: reset leaves outputs and counters cleared.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (!ais_flag && !ais_change && pos == '0 && zcnt == '0));

    // R2: position stays inside the window.
    p_pos_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pos) < WIN_LEN);

    // R2: unqualified cycles do not move the window.
    p_pos_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && run) |=> $stable(pos));

    // R3: zero count never passes its ceiling.
    p_zero_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(zcnt) <= ZERO_LIMIT);

    // R5: while running, the flag only moves right after a window end.
    p_flag_at_window_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ais_flag != $past(ais_flag)) |-> $past(win_end));

    // R8: the pulse marks a real toggle of the flag.
    p_change_marks_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ais_change |-> (ais_flag != $past(ais_flag)));

    // R8: the pulse lasts one cycle.
    p_change_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ais_change |=> !ais_change);

    // R9: idle clears window position and zero count.
    p_idle_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pos == '0 && zcnt == '0));

endmodule

bind ds2_ais_mon ds2_ais_mon_chk #(
    .WIN_LEN    (WIN_LEN),
    .ZERO_LIMIT (ZERO_LIMIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .src_mode   (src_mode),
    .ais_flag   (ais_flag),
    .ais_change (ais_change),
    .pos        (win_pos),
    .zcnt       (zero_cnt),
    .win_end    (win_end)
);

// File: tb/ds2_ais_mon_tb.sv
// Bench for ds2_ais_mon: directed window sequences plus seeded random
// windows, compared each cycle against a reference built from the rules.
module ds2_ais_mon_tb;

    localparam int WIN  = 840;
    localparam int LIM  = 5;
    localparam int WDOG = 200000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_en;
    logic       ser_data;
    logic [1:0] src_mode;
    logic       ais_flag;
    logic       ais_change;

    int    n_checks = 0;
    int    n_errors = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // Reference state
    int m_pos = 0;
    int m_zeros = 0;
    bit m_prev = 1'b0;
    bit m_flag = 1'b0;
    bit m_chg = 1'b0;

    always #4 clk = ~clk;

    ds2_ais_mon #(.WIN_LEN(WIN), .ZERO_LIMIT(LIM)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .ser_data   (ser_data),
        .src_mode   (src_mode),
        .ais_flag   (ais_flag),
        .ais_change (ais_change)
    );

    function automatic bit rate_quiet(input int zeros);
        return zeros < LIM;
    endfunction

    task automatic check(input string req, input bit act, input bit exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference update for one clock edge.
    task automatic model_edge(input bit en, input bit d, input logic [1:0] mode);
        if (!rst_n || mode[1]) begin
            m_pos = 0; m_zeros = 0; m_prev = 0; m_flag = 0; m_chg = 0;
        end else begin
            m_chg = 0;
            if (en) begin
                if (!d) m_zeros++;
                if (m_pos == WIN - 1) begin
                    bit q;
                    q = rate_quiet(m_zeros);
                    if (q == m_prev && q != m_flag) begin
                        m_flag = q;
                        m_chg  = 1;
                    end
                    m_prev  = q;
                    m_pos   = 0;
                    m_zeros = 0;
                end else begin
                    m_pos++;
                end
            end
        end
    endtask

    // One cycle: drive at negedge, take the edge, compare at next negedge.
    task automatic cycle(input bit en, input bit d, input logic [1:0] mode);
        bit_en   = en;
        ser_data = d;
        src_mode = mode;
        @(posedge clk);
        model_edge(en, d, mode);
        @(negedge clk);
        check(tag, ais_flag, m_flag && !mode[1], "ais_flag");
        check((tag == "R1") ? "R1" : "R8", ais_change, m_chg && !mode[1], "ais_change");
    endtask

    // One full window: nz zeros spread out, optional zero on last bit,
    // random unqualified cycles carrying random data.
    task automatic run_window(input int nz, input logic [1:0] mode, input bit last_zero);
        for (int p = 0; p < WIN; p++) begin
            bit d;
            int early;
            while ($urandom_range(0, 3) == 0) cycle(1'b0, 1'($urandom_range(0, 1)), mode);
            early = last_zero ? nz - 1 : nz;
            d = 1'b1;
            if (p < early * 7 && (p % 7) == 0) d = 1'b0;
            if (last_zero && nz > 0 && p == WIN - 1) d = 1'b0;
            cycle(1'b1, d, mode);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bit_en = 1'b0; ser_data = 1'b0; src_mode = 2'b00;
        @(negedge clk);
        // R1: reset state
        tag = "R1";
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            model_edge(1'b1, 1'b0, 2'b00);
            @(negedge clk);
            check("R1", ais_flag, 1'b0, "flag in reset");
            check("R1", ais_change, 1'b0, "pulse in reset");
        end
        rst_n = 1'b1;

        // R5: two quiet windows raise the flag
        tag = "R5";
        run_window(0, 2'b00, 1'b0);
        check("R5", ais_flag, 1'b0, "flag after one quiet window");
        run_window(4, 2'b00, 1'b0);
        check("R5", ais_flag, 1'b1, "flag after two quiet windows");

        // R7: one noisy window does not drop it
        tag = "R7";
        run_window(5, 2'b00, 1'b0);
        check("R7", ais_flag, 1'b1, "flag after lone noisy window");
        run_window(0, 2'b00, 1'b0);
        check("R7", ais_flag, 1'b1, "flag after quiet follow-up");

        // R4: boundary, 5 zeros with the last on the final bit is noisy
        tag = "R4";
        run_window(5, 2'b00, 1'b1);
        run_window(5, 2'b00, 1'b1);
        check("R4", ais_flag, 1'b0, "two 5-zero windows (last bit zero)");
        // 4 zeros with last on final bit is quiet
        run_window(4, 2'b00, 1'b1);
        run_window(4, 2'b00, 1'b1);
        check("R4", ais_flag, 1'b1, "two 4-zero windows (last bit zero)");

        // R6: two noisy windows clear it
        tag = "R6";
        run_window(6, 2'b00, 1'b0);
        check("R6", ais_flag, 1'b1, "flag after one noisy window");
        run_window(5, 2'b00, 1'b0);
        check("R6", ais_flag, 1'b0, "flag after two noisy windows");

        // R3: heavy zero windows still rate noisy after saturation
        tag = "R3";
        run_window(0, 2'b00, 1'b0);
        run_window(0, 2'b00, 1'b0);
        run_window(60, 2'b00, 1'b0);
        run_window(100, 2'b00, 1'b1);
        check("R3", ais_flag, 1'b0, "saturated windows clear flag");

        // R10: direct-input mode behaves the same
        tag = "R10";
        run_window(3, 2'b01, 1'b0);
        run_window(1, 2'b01, 1'b1);
        check("R10", ais_flag, 1'b1, "mode 01 raises flag");

        // R9: idle mid-window clears, restart needs two fresh quiet windows
        tag = "R9";
        for (int i = 0; i < 300; i++) cycle(1'b1, 1'b1, 2'b01);
        for (int i = 0; i < 20; i++) cycle(1'b1, 1'b1, 2'b10);
        check("R9", ais_flag, 1'b0, "flag low in mode 10");
        for (int i = 0; i < 20; i++) cycle(1'b1, 1'b1, 2'b11);
        check("R9", ais_flag, 1'b0, "flag low in mode 11");
        run_window(0, 2'b00, 1'b0);
        check("R9", ais_flag, 1'b0, "one quiet window after idle");
        run_window(0, 2'b00, 1'b0);
        check("R9", ais_flag, 1'b1, "two quiet windows after idle");

        // R2: unqualified zeros are ignored (gap cycles carry data 0)
        tag = "R2";
        for (int w = 0; w < 2; w++) begin
            for (int p = 0; p < WIN; p++) begin
                cycle(1'b0, 1'b0, 2'b00);
                cycle(1'b1, 1'b1, 2'b00);
            end
        end
        check("R2", ais_flag, 1'b1, "gap zeros not counted");

        // Random windows across both modes
        tag = "R4";
        for (int w = 0; w < 24; w++) begin
            int nz;
            int pick;
            pick = $urandom_range(0, 9);
            nz = (pick == 9) ? 40 : pick;
            run_window(nz, 2'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        for (int i = 0; i < WDOG; i++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule